// File: doc/BRIEF.md
# UART Loopback Register Datapath

This block holds the byte-wide register set of a classic PC-style serial port. It decodes a 3-bit offset and a divisor-access bit to reach the transmit holding register, the receive buffer, a 16-bit divisor, the interrupt enable bits, the line control, the modem control and the line status. A write to the transmit holding register starts a countdown of one character time. The length of that countdown comes from the divisor. When the countdown ends, the holding register is free again.

With the modem-control loopback bit set, the finished character lands in the receive buffer. If the previous byte was never read, an overrun is flagged. Single-cycle event pulses go to an external interrupt controller for transmit-empty, receive-data and line-status. The receive-data and line-status events are raised only while the second user output bit of modem control is set. The block does not drive a serial pin and has no FIFOs.

The register bus is a plain strobe interface: `bus_wr` and `bus_rd` are sampled at a rising clock edge. There is no back-pressure. Every access completes in the cycle it is presented. Read data is registered and is valid in the cycle after the read strobe.

Top module: `uart_loop_regs`

## Requirements
- R1: When line-control bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. When bit 7 is clear, offset 0 is the data buffer and offset 1 is the interrupt enable register.
- R2: A read at offset 0 with bit 7 clear returns the receive buffer and clears the data-ready bit (line status bit 0).
- R3: A byte accepted for transmission is ANDed with 0xFF shifted right by (3 minus line-control bits [1:0]). Select 0 keeps 5 bits and select 3 keeps 8 bits.
- R4: A transmit write while line status bit 5 (holding empty) is set clears bits 5 and 6 (transmitter empty). A transmit write while bit 5 is clear is ignored and does not change the character in flight.
- R5: The character time is max(divisor,1) shifted left by CHAR_SHIFT clock cycles, counted from the accepting edge. At its end, bits 5 and 6 are set again and `evt_tx` is high for exactly one cycle.
- R6: At the end of a character with modem-control bit 4 (loopback) set, the byte is copied into the receive buffer and data-ready is set. With loopback clear, the byte is discarded.
- R7: If data-ready is still set when a loopback byte arrives, line status bit 1 (overrun) is set and the new byte replaces the old one.
- R8: `evt_rx` and `evt_ls` each pulse for one cycle, together with `evt_tx`, on a loopback receive only when modem-control bit 3 (OUT2) is set. They stay low otherwise.
- R9: A read at offset 5 returns the line status and clears the overrun bit and the break bit (bit 4). Bit 7 reads as 0.
- R10: After reset, the line status reads 0x60, every other register reads 0, and all event outputs are low.
- R11: Offset 1 with bit 7 clear stores the low 4 bits of the written byte. It reads them back and drives them on `int_enable`.
- R12: Read data appears on `bus_rdata` one cycle after the read strobe. Offset 3 reads back line control in full and offset 4 reads back modem control bits [4:0]. Offsets 2, 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| int_enable | output | 4 | Stored interrupt enable bits |
| evt_tx | output | 1 | Transmit-empty event pulse |
| evt_rx | output | 1 | Loopback receive-data event pulse |
| evt_ls | output | 1 | Loopback line-status event pulse |

## Verification
Register results are due one cycle after the strobe. The bench drives each access on a falling edge and samples `bus_rdata` on the next falling edge, after exactly one rising edge. Event pulses are due max(divisor,1)<<CHAR_SHIFT edges after the accepting write edge. The bench counts falling edges from the end of the write and records the first one where `evt_tx` is high, then compares that index with the computed character time. Status side effects such as data-ready, overrun and holding-empty are checked by reading the line status through the bus once the window has closed.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 3;

  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_IEN  = 3'd1;
  localparam logic [OFS_W-1:0] OFS_LCTL = 3'd3;
  localparam logic [OFS_W-1:0] OFS_MCTL = 3'd4;
  localparam logic [OFS_W-1:0] OFS_LSTA = 3'd5;

  localparam int LCTL_DLAB  = 7;
  localparam int MCTL_OUT2  = 3;
  localparam int MCTL_LOOP  = 4;

  function automatic logic [BYTE_W-1:0] word_mask(input logic [1:0] wsel);
    logic [1:0] drop;
    drop = 2'd3 - wsel;
    return 8'hFF >> drop;
  endfunction
endpackage

// File: rtl/ureg_char_timer.sv
module ureg_char_timer #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= '0;
    else if (start)           remain <= load_val;
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  // last counted cycle: completion takes effect on the coming edge
  assign done = (remain == CNT_W'(1));
endmodule

// File: rtl/ureg_rx_slot.sv
module ureg_rx_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] cap_byte,
  input  logic         take,
  input  logic         stat_read,
  output logic [W-1:0] rx_byte,
  output logic         ready,
  output logic         overrun
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte <= '0;
      ready   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (capture) begin
        rx_byte <= cap_byte;
        ready   <= 1'b1;
      end else if (take) begin
        ready   <= 1'b0;
      end
      if (capture && ready) overrun <= 1'b1;
      else if (stat_read)   overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_loop_regs.sv
module uart_loop_regs
  import uart_reg_pkg::*;
#(
  parameter int CHAR_SHIFT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [3:0]        int_enable,
  output logic              evt_tx,
  output logic              evt_rx,
  output logic              evt_ls
);
  localparam int DIV_W = 2 * BYTE_W;
  localparam int CNT_W = DIV_W + CHAR_SHIFT;

  logic [BYTE_W-1:0] div_lo, div_hi, lctl, tx_hold;
  logic [4:0]        mctl;
  logic [3:0]        ien;
  logic              thr_empty, tsr_empty;
  logic              dlab, loop_en, out2_en;
  logic              char_done, tx_accept, rx_cap;
  logic [DIV_W-1:0]  div_eff;
  logic [CNT_W-1:0]  char_len;
  logic [BYTE_W-1:0] rx_byte;
  logic              rx_ready, rx_over;

  assign dlab    = lctl[LCTL_DLAB];
  assign loop_en = mctl[MCTL_LOOP];
  assign out2_en = mctl[MCTL_OUT2];

  // bus decode
  logic sel_data, sel_ien;
  assign sel_data = (bus_addr == OFS_DATA);
  assign sel_ien  = (bus_addr == OFS_IEN);

  logic wr_thr, wr_dlo, wr_dhi, wr_ien, rd_rbr, rd_lsta;
  assign wr_thr  = bus_wr && sel_data && !dlab;
  assign wr_dlo  = bus_wr && sel_data &&  dlab;
  assign wr_dhi  = bus_wr && sel_ien  &&  dlab;
  assign wr_ien  = bus_wr && sel_ien  && !dlab;
  assign rd_rbr  = bus_rd && sel_data && !dlab;
  assign rd_lsta = bus_rd && (bus_addr == OFS_LSTA);

  assign tx_accept = wr_thr && thr_empty;
  assign rx_cap    = char_done && loop_en;

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lo <= '0;
      div_hi <= '0;
      lctl   <= '0;
      mctl   <= '0;
      ien    <= '0;
    end else if (bus_wr) begin
      if (wr_dlo) div_lo <= bus_wdata;
      if (wr_dhi) div_hi <= bus_wdata;
      if (wr_ien) ien    <= bus_wdata[3:0];
      if (bus_addr == OFS_LCTL) lctl <= bus_wdata;
      if (bus_addr == OFS_MCTL) mctl <= bus_wdata[4:0];
    end
  end

  // character length derived from divisor
  assign div_eff = ({div_hi, div_lo} == '0) ? DIV_W'(1) : {div_hi, div_lo};

  generate
    if (CHAR_SHIFT == 0) begin : g_len_plain
      assign char_len = div_eff;
    end else begin : g_len_scaled
      assign char_len = {div_eff, {CHAR_SHIFT{1'b0}}};
    end
  endgenerate

  ureg_char_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (tx_accept),
    .load_val (char_len),
    .done     (char_done)
  );

  // transmit holding and empty flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold   <= '0;
      thr_empty <= 1'b1;
      tsr_empty <= 1'b1;
    end else if (char_done) begin
      thr_empty <= 1'b1;
      tsr_empty <= 1'b1;
    end else if (tx_accept) begin
      tx_hold   <= bus_wdata & word_mask(lctl[1:0]);
      thr_empty <= 1'b0;
      tsr_empty <= 1'b0;
    end
  end

  ureg_rx_slot #(.W(BYTE_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (rx_cap),
    .cap_byte  (tx_hold),
    .take      (rd_rbr),
    .stat_read (rd_lsta),
    .rx_byte   (rx_byte),
    .ready     (rx_ready),
    .overrun   (rx_over)
  );

  // event pulses toward the interrupt controller
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_tx <= 1'b0;
      evt_rx <= 1'b0;
      evt_ls <= 1'b0;
    end else begin
      evt_tx <= char_done;
      evt_rx <= rx_cap && out2_en;
      evt_ls <= rx_cap && out2_en;
    end
  end

  // registered read mux
  logic [BYTE_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_DATA: rd_mux = dlab ? div_lo : rx_byte;
      OFS_IEN:  rd_mux = dlab ? div_hi : {4'h0, ien};
      OFS_LCTL: rd_mux = lctl;
      OFS_MCTL: rd_mux = {3'b000, mctl};
      OFS_LSTA: rd_mux = {1'b0, tsr_empty, thr_empty, 3'b000, rx_over, rx_ready};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign int_enable = ien;
endmodule

// File: rtl/uart_loop_regs_chk.sv
module uart_loop_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [2:0] bus_addr,
  input logic       dlab,
  input logic       thre,
  input logic       temt,
  input logic       dr,
  input logic       oe,
  input logic       done,
  input logic       loop_en,
  input logic       out2_en,
  input logic       evt_tx,
  input logic       evt_rx,
  input logic       evt_ls
);
  // R4: accepted write empties both flags
  a_r4_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0 && !dlab && thre) |=> (!thre && !temt));

  // R5: completion refills flags and the tx event is a single pulse
  a_r5_done_refills: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (thre && temt && evt_tx));
  a_r5_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tx |=> !evt_tx);

  // R2: buffer read clears data ready unless a byte lands at the same edge
  a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd0 && !dlab && !(done && loop_en)) |=> !dr);

  // R7: arrival on a full buffer flags overrun
  a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (done && loop_en && dr) |=> oe);

  // R8: receive events only with OUT2 in loopback
  a_r8_out2_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(loop_en && out2_en)) |=> (!evt_rx && !evt_ls));

  // R9: status read clears overrun unless a new overrun arrives
  a_r9_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd5 && !(done && loop_en && dr)) |=> !oe);
endmodule

bind uart_loop_regs uart_loop_regs_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .dlab     (dlab),
  .thre     (thr_empty),
  .temt     (tsr_empty),
  .dr       (rx_ready),
  .oe       (rx_over),
  .done     (char_done),
  .loop_en  (loop_en),
  .out2_en  (out2_en),
  .evt_tx   (evt_tx),
  .evt_rx   (evt_rx),
  .evt_ls   (evt_ls)
);

// File: tb/uart_loop_regs_tb.sv
`timescale 1ns/1ps
module uart_loop_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] int_enable;
  logic       evt_tx, evt_rx, evt_ls;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  uart_loop_regs #(.CHAR_SHIFT(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .int_enable(int_enable), .evt_tx(evt_tx), .evt_rx(evt_rx), .evt_ls(evt_ls)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // send a byte and measure the edge of evt_tx and the count of rx/ls pulses
  task automatic send(input logic [7:0] d, input int exp_len, input int exp_rx, input string tag);
    int first = 0;
    int nrx = 0;
    int nls = 0;
    int ntx = 0;
    wr(3'd0, d);
    for (int k = 1; k <= exp_len + 3; k++) begin
      @(negedge clk);
      if (evt_tx) begin
        ntx++;
        if (first == 0) first = k;
      end
      if (evt_rx) nrx++;
      if (evt_ls) nls++;
    end
    check({tag, " R5 char time"}, first, exp_len);
    check({tag, " R5 tx pulse count"}, ntx, 1);
    check({tag, " R8 rx events"}, nrx, exp_rx);
    check({tag, " R8 ls events"}, nls, exp_rx);
  endtask

  // {is_write, offset, data, expected read}
  localparam int NV = 16;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 3'd3, 8'h83, 8'h00},  // R1 open divisor
    {1'b1, 3'd0, 8'h05, 8'h00},  // R1 divisor low
    {1'b1, 3'd1, 8'h00, 8'h00},  // R1 divisor high
    {1'b0, 3'd0, 8'h00, 8'h05},  // R1 read low
    {1'b0, 3'd1, 8'h00, 8'h00},  // R1 read high
    {1'b0, 3'd3, 8'h00, 8'h83},  // R12 line control
    {1'b1, 3'd3, 8'h03, 8'h00},  // close divisor
    {1'b1, 3'd1, 8'hFA, 8'h00},  // R11 enable bits
    {1'b0, 3'd1, 8'h00, 8'h0A},  // R11 read back
    {1'b0, 3'd2, 8'h00, 8'h00},  // R12 unmapped
    {1'b0, 3'd7, 8'h00, 8'h00},  // R12 unmapped
    {1'b1, 3'd4, 8'hFF, 8'h00},  // R12 modem control
    {1'b0, 3'd4, 8'h00, 8'h1F},  // R12 five bits kept
    {1'b1, 3'd3, 8'h83, 8'h00},  // R1 reopen
    {1'b0, 3'd1, 8'h00, 8'h00},  // R1 high byte, not enables
    {1'b1, 3'd3, 8'h03, 8'h00}   // close
  };

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R10 reset state
    check("R10 events", {evt_tx, evt_rx, evt_ls}, 0);
    check("R10 enables", int_enable, 0);
    rd(3'd5, 8'h60, "R10 line status");
    rd(3'd3, 8'h00, "R10 line control");
    rd(3'd0, 8'h00, "R10 rx buffer");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
      else rd(VEC[i][18:16], VEC[i][7:0], $sformatf("R1/R11/R12 vector %0d", i));
    end
    check("R11 int_enable pins", int_enable, 4'hA);

    // loopback with OUT2, divisor 5, shift 1 -> 10 cycles
    wr(3'd4, 8'h18);
    send(8'hA5, 10, 1, "R6 loop+out2");
    rd(3'd5, 8'h61, "R6 data ready after loopback");
    rd(3'd0, 8'hA5, "R6 received byte");
    rd(3'd5, 8'h60, "R2 data ready cleared");

    // R4 busy flags and rejected write
    wr(3'd0, 8'h11);
    rd(3'd5, 8'h00, "R4 both empty bits cleared");
    wr(3'd0, 8'h22);
    idle(12);
    rd(3'd0, 8'h11, "R4 second write ignored");

    // R3 word-length masking
    wr(3'd3, 8'h00);
    send(8'hFF, 10, 1, "R3 five bits");
    rd(3'd0, 8'h1F, "R3 five-bit mask");
    wr(3'd3, 8'h02);
    send(8'hFF, 10, 1, "R3 seven bits");
    rd(3'd0, 8'h7F, "R3 seven-bit mask");
    wr(3'd3, 8'h03);

    // R7 overrun then R9 status read clears it
    send(8'h3C, 10, 1, "R7 first");
    send(8'h5A, 10, 1, "R7 second");
    rd(3'd5, 8'h63, "R7 overrun flagged");
    rd(3'd5, 8'h61, "R9 overrun cleared by status read");
    rd(3'd0, 8'h5A, "R7 newest byte kept");

    // R8 OUT2 clear: no receive events, data still arrives
    wr(3'd4, 8'h10);
    send(8'h42, 10, 0, "R8 no out2");
    rd(3'd5, 8'h61, "R8 data still received");
    rd(3'd0, 8'h42, "R8 byte");

    // R6 no loopback: byte discarded
    wr(3'd4, 8'h08);
    send(8'h77, 10, 0, "R6 no loop");
    rd(3'd5, 8'h60, "R6 nothing received");

    // R5 zero divisor behaves as one -> 2 cycles
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h03);
    wr(3'd4, 8'h18);
    send(8'h99, 2, 1, "R5 zero divisor");
    rd(3'd0, 8'h99, "R5 zero divisor byte");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule